// File: doc/BRIEF.md
# Write-Forwarding Register File

This block is a general-purpose register file for a small in-order pipeline. It holds a set of data registers and offers two combinational read ports and one write port. A value presented on the write port in a given cycle is already visible on the read ports in that same cycle. A decode stage that reads its operands while an older instruction writes back therefore sees the fresh result. It does not have to stall for an extra cycle.

Index 0 is hardwired: it always reads as zero, and writes to it are dropped. A build-time parameter picks one of two internal structures. The first writes the storage array directly and forwards the incoming write to the readers. The second parks each write for one cycle in a single-entry holding slot. The slot is searched by both readers and is moved into the array on the next clock. Both structures behave the same at the ports.

Top module: `bypass_regfile`

## Requirements
- R1: After synchronous reset every register reads as zero on both read ports.
- R2: A write with `wr_en` high to a nonzero index stores `wr_data`. Later reads of that index return it until it is overwritten.
- R3: When a read index equals a nonzero `wr_idx` in a cycle with `wr_en` high, that read port returns `wr_data` in the same cycle.
- R4: Index 0 reads as zero on both ports at all times, including a cycle in which a write to index 0 is presented. A write to index 0 leaves no state behind.
- R5: The two read ports are independent: each returns the value of its own index, whether the indices are the same or differ.
- R6: With `wr_en` low, `wr_idx` and `wr_data` have no effect on any register.
- R7: Back-to-back writes to one index leave the newest value visible, both in the cycle of the second write and afterwards.
- R8: Writes on consecutive cycles to different indices are all retained. A write arriving while an earlier write is still being committed loses neither value.
- R9: Asserting reset again clears values written before it back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W (5) | Register index to write |
| wr_data | input | DATA_W (32) | Data to write |
| rd0_idx | input | IDX_W (5) | Read port 0 index |
| rd0_data | output | DATA_W (32) | Read port 0 data, combinational |
| rd1_idx | input | IDX_W (5) | Read port 1 index |
| rd1_data | output | DATA_W (32) | Read port 1 data, combinational |

## Verification
The bench drives both internal structures side by side against one reference model. It targets same-cycle forwarding on each port. A design that ordered its reads before its writes would return the stale value there. It also writes to index 0 and reads index 0 in the same cycle. A design lacking the zero guard on the forward path would leak the written data. Back-to-back writes to one index catch a holding slot that lets the draining older value win over the newer one. Consecutive writes to different indices catch a slot that overwrites its entry before that entry reaches the array.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Origin of the value returned by a read port.
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_HOLD  = 2'd2,
    SRC_ARRAY = 2'd3
  } rd_src_e;

endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [IDX_W-1:0]               widx,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   ridx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (we && widx != '0) begin
      regs[widx] <= wdata;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata[p] = (ridx[p] == '0) ? '0 : regs[ridx[p]];
  end

  // The committing path never targets the hardwired register.
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |-> widx != '0); // R4

endmodule

// File: rtl/rf_hold_slot.sv
module rf_hold_slot #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_en,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              hold_vld,
  output logic [IDX_W-1:0]  hold_idx,
  output logic [DATA_W-1:0] hold_data
);

  // The slot drains every cycle it is full. A new write reloads it in the
  // same edge, so the slot always holds the most recent write.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
    end else begin
      hold_vld <= in_en && (in_idx != '0);
      if (in_en && in_idx != '0) begin
        hold_idx  <= in_idx;
        hold_data <= in_data;
      end
    end
  end

  AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    hold_vld |-> hold_idx != '0); // R4

endmodule

// File: rtl/rf_fwd_mux.sv
module rf_fwd_mux
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  ridx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold_vld,
  input  logic [IDX_W-1:0]  hold_idx,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rdata
);

  rd_src_e src;

  // Priority: zero guard, then the write in flight, then the slot, then the array.
  always_comb begin
    if (ridx == '0)                         src = SRC_ZERO;
    else if (wr_en && wr_idx == ridx)       src = SRC_WRITE;
    else if (hold_vld && hold_idx == ridx)  src = SRC_HOLD;
    else                                    src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO:  rdata = '0;
      SRC_WRITE: rdata = wr_data;
      SRC_HOLD:  rdata = hold_data;
      default:   rdata = arr_data;
    endcase
  end

endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 32,
  parameter bit USE_SLOT   = 1'b1,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data
);

  localparam int NUM_RD = 2;

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0] arr_rdata;
  logic [NUM_RD-1:0][DATA_W-1:0] port_data;

  logic              hold_vld;
  logic [IDX_W-1:0]  hold_idx;
  logic [DATA_W-1:0] hold_data;
  logic              arr_we;
  logic [IDX_W-1:0]  arr_widx;
  logic [DATA_W-1:0] arr_wdata;

  assign rd_idx[0] = rd0_idx;
  assign rd_idx[1] = rd1_idx;
  assign rd0_data  = port_data[0];
  assign rd1_data  = port_data[1];

  if (USE_SLOT) begin : g_slot
    rf_hold_slot #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .in_en     (wr_en),
      .in_idx    (wr_idx),
      .in_data   (wr_data),
      .hold_vld  (hold_vld),
      .hold_idx  (hold_idx),
      .hold_data (hold_data)
    );
    assign arr_we    = hold_vld;
    assign arr_widx  = hold_idx;
    assign arr_wdata = hold_data;
  end else begin : g_direct
    assign hold_vld  = 1'b0;
    assign hold_idx  = '0;
    assign hold_data = '0;
    assign arr_we    = wr_en && (wr_idx != '0);
    assign arr_widx  = wr_idx;
    assign arr_wdata = wr_data;
  end

  rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .widx  (arr_widx),
    .wdata (arr_wdata),
    .ridx  (rd_idx),
    .rdata (arr_rdata)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    rf_fwd_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
      .ridx      (rd_idx[p]),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .hold_vld  (hold_vld),
      .hold_idx  (hold_idx),
      .hold_data (hold_data),
      .arr_data  (arr_rdata[p]),
      .rdata     (port_data[p])
    );
  end

  AST_ZERO_RD0: assert property (@(posedge clk) disable iff (rst)
    rd0_idx == '0 |-> rd0_data == '0); // R4
  AST_ZERO_RD1: assert property (@(posedge clk) disable iff (rst)
    rd1_idx == '0 |-> rd1_data == '0); // R4
  AST_FWD_RD0: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && rd0_idx == wr_idx) |-> rd0_data == wr_data); // R3
  AST_FWD_RD1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && rd1_idx == wr_idx) |-> rd1_data == wr_data); // R3
  AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_idx) != '0 && !wr_en
     && rd0_idx == $past(wr_idx)) |-> rd0_data == $past(wr_data)); // R2

endmodule

// File: tb/bypass_regfile_tb.sv
module bypass_regfile_tb;

  localparam int DW = 32;
  localparam int NR = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [IW-1:0] rd0_idx, rd1_idx;
  logic [DW-1:0] s_rd0, s_rd1, d_rd0, d_rd1;

  logic [DW-1:0] model [NR];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bypass_regfile #(.DATA_W(DW), .NUM_REGS(NR), .USE_SLOT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_data(s_rd0), .rd1_idx(rd1_idx), .rd1_data(s_rd1));

  bypass_regfile #(.DATA_W(DW), .NUM_REGS(NR), .USE_SLOT(1'b0)) u_dut_direct (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_data(d_rd0), .rd1_idx(rd1_idx), .rd1_data(d_rd1));

  function automatic logic [DW-1:0] expect_rd(input logic [IW-1:0] idx);
    if (idx == '0) return '0;
    if (wr_en && wr_idx == idx) return wr_data;
    return model[idx];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check comb reads, then commit model.
  task automatic step(input string req, input logic we, input logic [IW-1:0] wi,
                      input logic [DW-1:0] wd, input logic [IW-1:0] r0,
                      input logic [IW-1:0] r1);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; rd0_idx = r0; rd1_idx = r1;
    #1;
    check(req, "slot rd0",   s_rd0, expect_rd(r0));
    check(req, "slot rd1",   s_rd1, expect_rd(r1));
    check(req, "direct rd0", d_rd0, expect_rd(r0));
    check(req, "direct rd1", d_rd1, expect_rd(r1));
    @(posedge clk);
    if (we && wi != '0) model[wi] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
  endtask

  task automatic t_reset_zero(input string req);
    for (int i = 0; i < NR; i += 2) step(req, 1'b0, 5'd0, '0, IW'(i), IW'(i + 1));
  endtask

  task automatic t_write_read();
    for (int i = 1; i < 9; i++) step("R2", 1'b1, IW'(i), 32'hA000_0000 + i, 5'd0, 5'd0);
    step("R2", 1'b0, 5'd0, '0, 5'd3, 5'd8);
    step("R5", 1'b0, 5'd0, '0, 5'd5, 5'd2);
    step("R5", 1'b0, 5'd0, '0, 5'd6, 5'd6);
  endtask

  task automatic t_forward();
    step("R3", 1'b1, 5'd17, 32'hDEAD_BEEF, 5'd17, 5'd17);
    step("R3", 1'b1, 5'd18, 32'h1234_5678, 5'd17, 5'd18);
    step("R3", 1'b1, 5'd19, 32'h0BAD_F00D, 5'd19, 5'd2);
    step("R3", 1'b0, 5'd0, '0, 5'd18, 5'd19);
  endtask

  task automatic t_zero_reg();
    step("R4", 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    step("R4", 1'b0, 5'd0, '0, 5'd0, 5'd0);
    step("R4", 1'b1, 5'd0, 32'h5555_AAAA, 5'd0, 5'd4);
  endtask

  task automatic t_no_enable();
    step("R6", 1'b1, 5'd9, 32'h0000_0099, 5'd0, 5'd0);
    step("R6", 1'b0, 5'd9, 32'hCAFE_CAFE, 5'd9, 5'd9);
    step("R6", 1'b0, 5'd9, 32'hCAFE_CAFE, 5'd9, 5'd1);
  endtask

  task automatic t_same_index();
    step("R7", 1'b1, 5'd12, 32'h1111_1111, 5'd12, 5'd0);
    step("R7", 1'b1, 5'd12, 32'h2222_2222, 5'd12, 5'd12);
    step("R7", 1'b0, 5'd0, '0, 5'd12, 5'd12);
    step("R7", 1'b0, 5'd0, '0, 5'd12, 5'd0);
  endtask

  task automatic t_diff_index();
    step("R8", 1'b1, 5'd20, 32'h2020_2020, 5'd0, 5'd0);
    step("R8", 1'b1, 5'd21, 32'h2121_2121, 5'd20, 5'd21);
    step("R8", 1'b1, 5'd22, 32'h2222_0022, 5'd20, 5'd21);
    step("R8", 1'b0, 5'd0, '0, 5'd20, 5'd21);
    step("R8", 1'b0, 5'd0, '0, 5'd22, 5'd20);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd0_idx = '0; rd1_idx = '0;
    do_reset();
    t_reset_zero("R1");
    t_write_read();
    t_forward();
    t_zero_reg();
    t_no_enable();
    t_same_index();
    t_diff_index();
    do_reset();
    t_reset_zero("R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule